// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs a 10-bit successive-approximation conversion from one system clock. A free-running power-of-two prescaler divides the system clock into a slower conversion clock. The conversion clock period is 128 system clocks by default, or 64 when the fast ratio is selected. A start request is registered and held pending. The conversion then begins on the next rising edge of the conversion clock, so the start latency depends on the prescaler phase.

During a conversion the block drives a trial code to an external DAC and comparator. It resolves one bit per conversion-clock period, most significant bit first. The comparator only reports above or below, never equal, so all ten bits are always tried. The length of a conversion therefore never depends on the input. A normal conversion lasts 13 conversion-clock periods. The first conversion after enabling, and the first one after the channel select changes, lasts 25 periods. When a conversion ends, the result register updates and a one-cycle done pulse is raised.

Top module: `sar_seq_top`

## Requirements
- R1: The conversion clock has a rising edge once every 128 system clocks when `fast_div` is 0, and once every 64 system clocks when it is 1. The prescaler counts from reset and is never restarted by a start request.
- R2: A start request accepted while idle begins the conversion (`busy` rises) at the first conversion-clock edge after the request cycle. The latency from the request cycle to `busy` is therefore between 1 and one full conversion-clock period of system clocks.
- R3: A normal conversion keeps `busy` high for exactly 13 conversion-clock periods (13×128 system clocks at the default ratio).
- R4: The first conversion after `enable` goes high, and any conversion whose `chan_sel` differs from the channel of the previous conversion, keeps `busy` high for 25 conversion-clock periods.
- R5: Within a conversion of L periods, periods L-10 to L-1 decide bits 9 down to 0, one bit per period. During such a period, `trial` equals the bits already decided with the current bit set. At the end of the period that bit is kept if `cmp_hi` is 1 (input at or above `trial`) and cleared otherwise. During the earlier overhead periods `trial` is 0.
- R6: The conversion length is the same for every input value, including all-zero and full-scale inputs, and the result equals the input code of an ideal comparator.
- R7: `done` is high for exactly one system clock, in the cycle in which `result` first shows the new value and `busy` has just fallen. At all other times `result` holds its value.
- R8: A start request while `busy` is high, or while `enable` is low, has no effect: no conversion follows it.
- R9: While `enable` is low the sequencer is idle, with `busy` low, and the next conversion after re-enabling uses the 25-period length.
- R10: After reset `busy`, `done`, `result` and `trial` are all 0. After a conversion, `trial` keeps the final code until the next conversion begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Sequencer enable; low forces idle and re-arms the long first conversion |
| fast_div | input | 1 | Prescaler select: 0 divides by 128, 1 divides by 64 |
| start | input | 1 | Conversion request, one system clock wide |
| chan_sel | input | 3 | Channel of the requested conversion |
| cmp_hi | input | 1 | Comparator: 1 when the sampled input is at or above the trial level |
| trial | output | 10 | Trial code driven to the DAC |
| busy | output | 1 | High while a conversion is in progress |
| result | output | 10 | Last completed conversion code |
| done | output | 1 | One-cycle pulse when `result` updates |

## Verification
The bench builds the block with its default parameters: a 7-bit prescaler, 10 result bits and the 13 and 25 period lengths. Because the divide ratio is a run-time input, both the 128 and 64 ratios and their different start-latency windows are reached without rebuilding. The default lengths keep a long conversion at 3200 system clocks. That leaves room in one run for long and short conversions, all-zero and full-scale inputs, channel switches, a disable and re-enable, and start requests that must be ignored.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;
  // Prescaler ratio choice as seen on the fast_div pin.
  typedef enum logic {
    DIV_SLOW = 1'b0,
    DIV_FAST = 1'b1
  } div_sel_e;
endpackage

// File: rtl/sar_seq_presc.sv
`timescale 1ns/1ps
module sar_seq_presc #(
  parameter int PRESC_W = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast,
  output logic tick
);
  import sar_seq_pkg::*;

  logic [PRESC_W-1:0] cnt_q;
  logic [PRESC_W-1:0] cnt_d;
  div_sel_e           sel;

  always_comb begin
    sel   = div_sel_e'(fast);
    cnt_d = cnt_q + 1'b1;
    if (sel == DIV_FAST) tick = &cnt_q[PRESC_W-2:0];
    else                 tick = &cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sar_seq_ctrl.sv
`timescale 1ns/1ps
module sar_seq_ctrl #(
  parameter int RES_BITS  = 10,
  parameter int SHORT_LEN = 13,
  parameter int LONG_LEN  = 25,
  parameter int CH_W      = 3,
  localparam int PW       = $clog2(LONG_LEN + 1),
  localparam int IW       = $clog2(RES_BITS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            start,
  input  logic            tick,
  input  logic [CH_W-1:0] chan,
  output logic            busy,
  output logic            launch,
  output logic            fin,
  output logic            dec_en,
  output logic            trial_en,
  output logic [IW-1:0]   dec_idx
);
  localparam logic [PW-1:0] SHORT_P = PW'(SHORT_LEN);
  localparam logic [PW-1:0] LONG_P  = PW'(LONG_LEN);
  localparam logic [PW-1:0] RES_P   = PW'(RES_BITS);
  localparam logic [PW-1:0] ONE_P   = PW'(1);

  logic            pend_q, pend_d;
  logic            busy_q, busy_d;
  logic            long_q, long_d;
  logic [PW-1:0]   per_q, per_d;
  logic [PW-1:0]   len_q, len_d;
  logic [CH_W-1:0] last_q, last_d;
  logic [PW-1:0]   idx_w;
  logic            in_bits;

  always_comb begin
    launch   = enable && !busy_q && pend_q && tick;
    in_bits  = busy_q && (per_q >= (len_q - RES_P)) && (per_q < len_q);
    trial_en = in_bits;
    dec_en   = enable && in_bits && tick;
    fin      = enable && busy_q && tick && (per_q == len_q);
    idx_w    = len_q - ONE_P - per_q;
    dec_idx  = idx_w[IW-1:0];
    busy     = busy_q;
  end

  always_comb begin
    pend_d = pend_q;
    busy_d = busy_q;
    long_d = long_q;
    per_d  = per_q;
    len_d  = len_q;
    last_d = last_q;
    if (!enable) begin
      pend_d = 1'b0;
      busy_d = 1'b0;
      long_d = 1'b1;
    end else begin
      if (launch) begin
        busy_d = 1'b1;
        per_d  = ONE_P;
        len_d  = (long_q || (chan != last_q)) ? LONG_P : SHORT_P;
        last_d = chan;
        long_d = 1'b0;
        pend_d = 1'b0;
      end else if (fin) begin
        busy_d = 1'b0;
      end else if (busy_q && tick) begin
        per_d = per_q + ONE_P;
      end
      if (!launch && start && !busy_q) pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      long_q <= 1'b1;
      per_q  <= '0;
      len_q  <= SHORT_P;
      last_q <= '0;
    end else begin
      pend_q <= pend_d;
      busy_q <= busy_d;
      long_q <= long_d;
      per_q  <= per_d;
      len_q  <= len_d;
      last_q <= last_d;
    end
  end
endmodule

// File: rtl/sar_seq_bits.sv
`timescale 1ns/1ps
module sar_seq_bits #(
  parameter int RES_BITS = 10,
  localparam int IW      = $clog2(RES_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                dec_en,
  input  logic                trial_en,
  input  logic [IW-1:0]       dec_idx,
  input  logic                cmp_hi,
  output logic [RES_BITS-1:0] acc,
  output logic [RES_BITS-1:0] trial
);
  logic [RES_BITS-1:0] acc_q, acc_d;
  logic [RES_BITS-1:0] probe;

  always_comb begin
    probe = '0;
    for (int i = 0; i < RES_BITS; i++) begin
      if (dec_idx == IW'(i)) probe[i] = 1'b1;
    end
    acc_d = acc_q;
    if (clr) begin
      acc_d = '0;
    end else if (dec_en) begin
      for (int i = 0; i < RES_BITS; i++) begin
        if (probe[i]) acc_d[i] = cmp_hi;
      end
    end
    trial = acc_q | (trial_en ? probe : '0);
    acc   = acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/sar_seq_top.sv
`timescale 1ns/1ps
module sar_seq_top #(
  parameter int PRESC_W   = 7,
  parameter int RES_BITS  = 10,
  parameter int SHORT_LEN = 13,
  parameter int LONG_LEN  = 25,
  parameter int CH_W      = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                fast_div,
  input  logic                start,
  input  logic [CH_W-1:0]     chan_sel,
  input  logic                cmp_hi,
  output logic [RES_BITS-1:0] trial,
  output logic                busy,
  output logic [RES_BITS-1:0] result,
  output logic                done
);
  localparam int IW = $clog2(RES_BITS);

  logic                tick;
  logic                launch;
  logic                fin;
  logic                dec_en;
  logic                trial_en;
  logic [IW-1:0]       dec_idx;
  logic [RES_BITS-1:0] acc;
  logic [RES_BITS-1:0] result_q, result_d;
  logic                done_q, done_d;

  sar_seq_presc #(.PRESC_W(PRESC_W)) presc_i (
    .clk  (clk),
    .rst_n(rst_n),
    .fast (fast_div),
    .tick (tick)
  );

  sar_seq_ctrl #(
    .RES_BITS (RES_BITS),
    .SHORT_LEN(SHORT_LEN),
    .LONG_LEN (LONG_LEN),
    .CH_W     (CH_W)
  ) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .start   (start),
    .tick    (tick),
    .chan    (chan_sel),
    .busy    (busy),
    .launch  (launch),
    .fin     (fin),
    .dec_en  (dec_en),
    .trial_en(trial_en),
    .dec_idx (dec_idx)
  );

  sar_seq_bits #(.RES_BITS(RES_BITS)) bits_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (launch),
    .dec_en  (dec_en),
    .trial_en(trial_en),
    .dec_idx (dec_idx),
    .cmp_hi  (cmp_hi),
    .acc     (acc),
    .trial   (trial)
  );

  always_comb begin
    result_d = fin ? acc : result_q;
    done_d   = fin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      result_q <= result_d;
      done_q   <= done_d;
    end
  end

  assign result = result_q;
  assign done   = done_q;
endmodule

// File: rtl/sar_seq_chk.sv
`timescale 1ns/1ps
module sar_seq_chk #(
  parameter int RES_BITS = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic                enable,
  input logic                start,
  input logic                busy,
  input logic                done,
  input logic [RES_BITS-1:0] trial,
  input logic [RES_BITS-1:0] result
);
  // R7: the completion pulse lasts a single cycle
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: the pulse coincides with the end of a conversion
  p_done_busy_fell_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(busy));

  // R7: result only moves together with the pulse
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  // R9: disabling forces idle
  p_disable_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !busy);

  // R5: the first period of a conversion is overhead with a cleared trial code
  p_trial_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (trial == '0));

  // R8: a request while disabled never starts a conversion on the next edge
  p_no_start_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !busy) |=> !busy);
endmodule

bind sar_seq_top sar_seq_chk #(.RES_BITS(RES_BITS)) chk_i (
  .clk   (clk),
  .rst_n (rst_n),
  .enable(enable),
  .start (start),
  .busy  (busy),
  .done  (done),
  .trial (trial),
  .result(result)
);

// File: tb/sar_seq_top_tb_top.sv
`timescale 1ns/1ps
module sar_seq_top_tb_top;
  logic       clk;
  logic       rst_n;
  logic       enable;
  logic       fast_div;
  logic       start;
  logic [2:0] chan_sel;
  logic       cmp_hi;
  logic [9:0] trial;
  logic       busy;
  logic [9:0] result;
  logic       done;

  int vin;
  int total;
  int bad;
  bit cmp_on;
  bit finished;

  sar_seq_top dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .fast_div(fast_div),
    .start   (start),
    .chan_sel(chan_sel),
    .cmp_hi  (cmp_hi),
    .trial   (trial),
    .busy    (busy),
    .result  (result),
    .done    (done)
  );

  // ideal comparator against the digital input level
  assign cmp_hi = (vin >= int'(trial));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // ---------------- behavioural reference ----------------
  int  m_cnt, m_per, m_len, m_acc, m_res, m_last;
  bit  m_pend, m_busy, m_long, m_done;

  function automatic int m_trial();
    if (m_busy && m_per >= m_len - 10 && m_per < m_len)
      return m_acc | (1 << (m_len - 1 - m_per));
    return m_acc;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_per = 0; m_len = 13; m_acc = 0; m_res = 0; m_last = 0;
      m_pend = 0; m_busy = 0; m_long = 1; m_done = 0;
    end else begin
      int  d;
      bit  edge_c;
      bit  old_busy;
      bit  began;
      int  t;
      d = fast_div ? 64 : 128;
      edge_c = ((m_cnt % d) == d - 1);
      m_cnt++;
      old_busy = m_busy;
      began = 0;
      m_done = 0;
      if (!enable) begin
        m_pend = 0; m_busy = 0; m_long = 1;
      end else begin
        if (m_busy && edge_c) begin
          if (m_per == m_len) begin
            m_res = m_acc; m_done = 1; m_busy = 0;
          end else begin
            if (m_per >= m_len - 10) begin
              t = m_trial();
              if (vin >= t) m_acc = t;
            end
            m_per++;
          end
        end else if (!m_busy && m_pend && edge_c) begin
          began = 1;
          m_busy = 1; m_per = 1; m_acc = 0;
          m_len = (m_long || int'(chan_sel) != m_last) ? 25 : 13;
          m_last = int'(chan_sel); m_long = 0; m_pend = 0;
        end
        if (!began && start && !old_busy) m_pend = 1;
      end
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n && cmp_on && !finished) begin
      check(busy == m_busy, "R2/R3/R4", "busy vs model", busy, m_busy);
      check(done == m_done, "R7", "done vs model", done, m_done);
      check(int'(result) == m_res, "R7", "result vs model", result, m_res);
      check(int'(trial) == m_trial(), "R5", "trial vs model", trial, m_trial());
    end
  end

  task automatic run_conv(int v, int ch, int exp_len, int d, string req_len);
    int lat;
    int len;
    vin = v; chan_sel = 3'(ch);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!busy && lat < 4000) begin
      @(negedge clk);
      lat++;
    end
    check(lat >= 1 && lat <= d, "R2", "start latency", lat, d);
    len = 0;
    while (busy && len < 8000) begin
      len++;
      @(negedge clk);
    end
    check(len == exp_len * d, req_len, "busy length", len, exp_len * d);
    check(done == 1'b1, "R7", "done at end", done, 1);
    check(int'(result) == v, "R6", "result code", result, v);
    check(int'(trial) == v, "R10", "trial holds final code", trial, v);
    @(negedge clk);
    check(done == 1'b0, "R7", "done single cycle", done, 0);
  endtask

  initial begin
    total = 0; bad = 0; cmp_on = 0; finished = 0;
    rst_n = 1'b0; enable = 1'b0; fast_div = 1'b0; start = 1'b0;
    chan_sel = 3'd0; vin = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(busy == 1'b0, "R10", "busy after reset", busy, 0);
    check(done == 1'b0, "R10", "done after reset", done, 0);
    check(result == '0, "R10", "result after reset", result, 0);
    check(trial == '0, "R10", "trial after reset", trial, 0);
    rst_n = 1'b1;
    cmp_on = 1;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    // R4: first conversion after enabling is long
    run_conv(677, 0, 25, 128, "R4");
    // R3, R6: normal length, full-scale and zero inputs
    run_conv(1023, 0, 13, 128, "R3");
    run_conv(0, 0, 13, 128, "R6");
    run_conv(341, 0, 13, 128, "R3");
    // R4: channel change
    run_conv(512, 5, 25, 128, "R4");
    run_conv(511, 5, 13, 128, "R3");
    // R1: fast ratio
    fast_div = 1'b1;
    repeat (130) @(negedge clk);
    run_conv(1, 5, 13, 64, "R1");
    run_conv(1000, 5, 13, 64, "R1");
    // R8: start while busy is ignored
    vin = 200; chan_sel = 3'd5;
    start = 1'b1; @(negedge clk); start = 1'b0;
    while (!busy) @(negedge clk);
    repeat (300) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    while (busy) @(negedge clk);
    repeat (200) @(negedge clk);
    check(busy == 1'b0, "R8", "no conversion after busy start", busy, 0);
    check(int'(result) == 200, "R8", "result of first request", result, 200);
    // R8, R9: disabled sequencer ignores start
    enable = 1'b0;
    @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (300) @(negedge clk);
    check(busy == 1'b0, "R9", "idle while disabled", busy, 0);
    check(int'(result) == 200, "R8", "result untouched while disabled", result, 200);
    enable = 1'b1;
    @(negedge clk);
    // R9: long conversion after re-enable, same channel
    fast_div = 1'b0;
    repeat (130) @(negedge clk);
    run_conv(853, 5, 25, 128, "R9");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule